// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

This block takes a received byte stream, qualified by frame-start, frame-end and per-frame error and address-class flags, and stores each frame as a record in a circular byte buffer. The buffer sits behind a synchronous byte-wide RAM write port. Each record is a 4-byte little-endian header followed by the frame bytes. The header packs a 16-bit status word and the 16-bit byte count. The block keeps the hardware write offset. Software consumes records through a read-pointer register that is biased by 16. A buffer-empty flag tells software when no unread record is left.

The hardware write offset only moves once a record's last byte has been written, so software never sees a partial record. A frame that would run into unread data is discarded whole and flagged. Nothing unread is ever overwritten. A frame start that arrives while the previous header is still being written is discarded and flagged as an input overrun. Three write-one-to-clear flags report these events and the arrival of good frames.

Top module: `rx_ring_writer`

## Requirements
- R1: Each record starts with a 4-byte header written little-endian at the record offset. Bytes 0–1 hold the status word and bytes 2–3 hold the frame length, which is the number of streamed bytes and so includes the FCS.
- R2: Status word bits: bit 0 is set when all five error inputs are low. Bits 1..5 copy `rx_errs[0..4]` (alignment, CRC, too long, runt, bad symbol). Bits 13, 14 and 15 copy `rx_kind[0..2]` (broadcast, unicast match, multicast). All other bits are 0.
- R3: Frame byte i is written at (record offset + 4 + i) mod ring size, so writes past the ring end wrap to offset 0.
- R4: After reset the first record is at offset 0. Each stored record advances the write offset by its length plus 4, rounded up to a multiple of 4, modulo the ring size.
- R5: The read-pointer register resets to 0xFFF0 and holds whatever software writes to it. The consumed offset is (register + 16) mod ring size. `buf_empty` is 1 exactly when the consumed offset equals the write offset. A record becomes visible on the fifth rising edge after the edge that samples its last byte.
- R6: A frame of length L is stored only if round4(L + 4) is less than the free space, where free space is the ring size minus ((write offset − consumed offset) mod ring size). Otherwise the frame is dropped whole: the write offset does not move, no header is written, and interrupt bit 4 is set.
- R7: `irq_flags` bit 0 is set when a record whose status bit 0 is 1 is committed. A flag bit is cleared by writing 1 to it through `irq_clr_data`. A set in the same cycle wins over a clear. Bits other than 0, 4 and 6 read 0.
- R8: The ring size is 2^(BASE_LOG2 + index), with index 3 treated as 2. Every RAM write address is below the ring size.
- R9: A frame start sampled within the 5 cycles that follow a frame end is dropped whole and sets interrupt bit 6. The pending record is still stored.
- R10: Bytes that arrive outside a frame (no start seen) produce no RAM writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size_idx | input | 2 | Ring size index (change only in reset) |
| rx_valid | input | 1 | Byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_errs | input | 5 | Error flags, valid with `rx_eof` |
| rx_kind | input | 3 | Address class flags, valid with `rx_eof` |
| mem_we | output | 1 | RAM byte write enable |
| mem_addr | output | BASE_LOG2+2 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| swp_we | input | 1 | Read-pointer register write strobe |
| swp_wdata | input | 16 | Read-pointer write value |
| swp_q | output | 16 | Read-pointer register value |
| buf_empty | output | 1 | No unread record |
| irq_clr_we | input | 1 | Interrupt clear strobe |
| irq_clr_data | input | 16 | Ones clear the matching flag bits |
| irq_flags | output | 16 | Interrupt flags (bits 0, 4, 6) |

## Verification
The bench builds the block with BASE_LOG2 = 6, which gives rings of 64, 128 and 256 bytes. At these sizes a sweep over every frame length up to half the ring plus ten wraps records past the ring end many times. Leaving every fifth record unconsumed fills the ring, so each sweep also drives the space check through both its fit and its drop outcomes. The bench predicts every header, payload byte, offset and drop from its own arithmetic.

// File: rtl/rrw_pkg.sv
package rrw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DATA,
    S_DROP,
    S_HDR,
    S_DONE
  } wr_state_e;

  localparam int IRQ_W        = 16;
  localparam int IRQ_RXOK     = 0;
  localparam int IRQ_RING_OVF = 4;
  localparam int IRQ_FIFO_OVF = 6;
  localparam int PTR_BIAS     = 16;

  // Round a byte count up to the next multiple of four.
  function automatic logic [31:0] round4(input logic [31:0] v);
    return (v + 32'd3) & ~32'd3;
  endfunction

  // Size index 3 behaves as index 2.
  function automatic logic [1:0] eff_idx(input logic [1:0] idx);
    return (idx == 2'd3) ? 2'd2 : idx;
  endfunction

  // Status word of a record header.
  function automatic logic [15:0] pack_status(input logic [4:0] errs,
                                              input logic [2:0] kind);
    logic [15:0] s;
    s        = '0;
    s[0]     = (errs == 5'd0);
    s[5:1]   = errs;
    s[15:13] = kind;
    return s;
  endfunction

endpackage

// File: rtl/rrw_space.sv
module rrw_space #(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] wptr,
  input  logic [ADDR_W-1:0] cons,
  input  logic [ADDR_W-1:0] ring_mask,
  input  logic [ADDR_W:0]   ring_size,
  output logic [ADDR_W:0]   free_bytes
);
  logic [ADDR_W-1:0] used;

  always_comb begin
    used       = (wptr - cons) & ring_mask;
    free_bytes = ring_size - {1'b0, used};
  end
endmodule

// File: rtl/rrw_swptr.sv
module rrw_swptr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [15:0]       wdata,
  input  logic [ADDR_W-1:0] ring_mask,
  input  logic [ADDR_W-1:0] wptr,
  output logic [15:0]       q,
  output logic [ADDR_W-1:0] cons,
  output logic              empty
);
  localparam logic [15:0] RESET_VAL = 16'(-rrw_pkg::PTR_BIAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL;
    else if (we) q <= wdata;
  end

  always_comb begin
    cons  = ADDR_W'(16'(q + 16'(rrw_pkg::PTR_BIAS))) & ring_mask;
    empty = (cons == wptr);
  end
endmodule

// File: rtl/rrw_irq.sv
module rrw_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] flags
);
  logic [W-1:0] clr_mask;

  assign clr_mask = clr_we ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set_vec;
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rrw_pkg::*;
#(
  parameter  int BASE_LOG2 = 13,
  localparam int ADDR_W    = BASE_LOG2 + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_size_idx,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic [4:0]        rx_errs,
  input  logic [2:0]        rx_kind,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              swp_we,
  input  logic [15:0]       swp_wdata,
  output logic [15:0]       swp_q,
  output logic              buf_empty,
  input  logic              irq_clr_we,
  input  logic [15:0]       irq_clr_data,
  output logic [15:0]       irq_flags
);
  // Ring geometry
  logic [1:0]        idx_e;
  logic [ADDR_W:0]   ring_size;
  logic [ADDR_W-1:0] ring_mask;

  assign idx_e     = eff_idx(cfg_size_idx);
  assign ring_size = (ADDR_W+1)'(1) << (BASE_LOG2 + int'(idx_e));
  assign ring_mask = ADDR_W'(ring_size - (ADDR_W+1)'(1));

  // State
  wr_state_e         state;
  logic [ADDR_W-1:0] wptr;
  logic [15:0]       cnt;
  logic [31:0]       hdr;
  logic [1:0]        hcnt;

  // Pointer and space
  logic [ADDR_W-1:0] cons;
  logic [ADDR_W:0]   free_bytes;

  rrw_swptr #(.ADDR_W(ADDR_W)) u_swptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (swp_we),
    .wdata     (swp_wdata),
    .ring_mask (ring_mask),
    .wptr      (wptr),
    .q         (swp_q),
    .cons      (cons),
    .empty     (buf_empty)
  );

  rrw_space #(.ADDR_W(ADDR_W)) u_space (
    .wptr       (wptr),
    .cons       (cons),
    .ring_mask  (ring_mask),
    .ring_size  (ring_size),
    .free_bytes (free_bytes)
  );

  // Byte acceptance and named events
  logic              in_frame_ok;
  logic              first_byte, next_byte, take;
  logic [15:0]       byte_idx, byte_len;
  logic              byte_fits;
  logic [ADDR_W-1:0] byte_addr, hdr_addr, next_wptr;
  logic              ev_ring_ovf, ev_fifo_ovf, ev_commit, ev_rxok;

  always_comb begin
    in_frame_ok = (state == S_IDLE) || (state == S_DATA) || (state == S_DROP);
    first_byte  = rx_valid && rx_sof && in_frame_ok;
    next_byte   = rx_valid && !rx_sof && (state == S_DATA);
    take        = first_byte || next_byte;
    byte_idx    = first_byte ? 16'd0 : cnt;
    byte_len    = byte_idx + 16'd1;
    byte_fits   = round4(32'd5 + 32'(byte_idx)) < 32'(free_bytes);
    byte_addr   = ADDR_W'(32'(wptr) + 32'd4 + 32'(byte_idx)) & ring_mask;
    hdr_addr    = ADDR_W'(32'(wptr) + 32'(hcnt)) & ring_mask;
    next_wptr   = ADDR_W'(32'(wptr) + round4(32'd4 + 32'(hdr[31:16]))) & ring_mask;
    ev_ring_ovf = take && !byte_fits;
    ev_fifo_ovf = rx_valid && rx_sof && ((state == S_HDR) || (state == S_DONE));
    ev_commit   = (state == S_DONE);
    ev_rxok     = ev_commit && hdr[0];
  end

  // Interrupt flags
  logic [IRQ_W-1:0] irq_set;

  always_comb begin
    irq_set               = '0;
    irq_set[IRQ_RXOK]     = ev_rxok;
    irq_set[IRQ_RING_OVF] = ev_ring_ovf;
    irq_set[IRQ_FIFO_OVF] = ev_fifo_ovf;
  end

  rrw_irq #(.W(IRQ_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (irq_set),
    .clr_we   (irq_clr_we),
    .clr_data (irq_clr_data),
    .flags    (irq_flags)
  );

  // Record writer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      wptr      <= '0;
      cnt       <= '0;
      hdr       <= '0;
      hcnt      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      unique case (state)
        S_IDLE, S_DATA, S_DROP: begin
          if (take) begin
            if (byte_fits) begin
              mem_we    <= 1'b1;
              mem_addr  <= byte_addr;
              mem_wdata <= rx_data;
              cnt       <= byte_len;
              if (rx_eof) begin
                hdr   <= {byte_len, pack_status(rx_errs, rx_kind)};
                hcnt  <= '0;
                state <= S_HDR;
              end else begin
                state <= S_DATA;
              end
            end else begin
              state <= rx_eof ? S_IDLE : S_DROP;
            end
          end else if ((state == S_DROP) && rx_valid && rx_eof) begin
            state <= S_IDLE;
          end
        end
        S_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= hdr_addr;
          mem_wdata <= hdr[{hcnt, 3'b000} +: 8];
          hcnt      <= hcnt + 2'd1;
          if (hcnt == 2'd3) state <= S_DONE;
        end
        S_DONE: begin
          wptr  <= next_wptr;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rrw_checker.sv
module rrw_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W:0]   ring_size,
  input logic              ev_ring_ovf,
  input logic              ev_fifo_ovf,
  input logic              ev_rxok,
  input logic              ev_commit,
  input logic              irq_rxok,
  input logic              irq_ring,
  input logic              irq_fifo,
  input logic              irq_clr_we,
  input logic              irq_clr_b0,
  input logic              swp_we,
  input logic [15:0]       swp_wdata,
  input logic [15:0]       swp_q,
  input logic              buf_empty
);
  p_addr_in_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_addr} < ring_size));

  p_drop_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ring_ovf |=> !mem_we);

  p_drop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ring_ovf |=> irq_ring);

  p_overrun_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fifo_ovf |=> irq_fifo);

  p_rxok_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxok |=> irq_rxok);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_we && irq_clr_b0 && !ev_rxok) |=> !irq_rxok);

  p_visible_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_empty) |-> ($past(ev_commit) || $past(swp_we)));

  p_swp_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swp_we |=> (swp_q == $past(swp_wdata)));
endmodule

bind rx_ring_writer rrw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .ring_size   (ring_size),
  .ev_ring_ovf (ev_ring_ovf),
  .ev_fifo_ovf (ev_fifo_ovf),
  .ev_rxok     (ev_rxok),
  .ev_commit   (ev_commit),
  .irq_rxok    (irq_flags[0]),
  .irq_ring    (irq_flags[4]),
  .irq_fifo    (irq_flags[6]),
  .irq_clr_we  (irq_clr_we),
  .irq_clr_b0  (irq_clr_data[0]),
  .swp_we      (swp_we),
  .swp_wdata   (swp_wdata),
  .swp_q       (swp_q),
  .buf_empty   (buf_empty)
);

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
  localparam int BL   = 6;
  localparam int AW   = BL + 2;
  localparam int RAMN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5ns clk = ~clk;

  logic [1:0]    cfg_size_idx = 2'd0;
  logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]    rx_data = 8'd0;
  logic [4:0]    rx_errs = 5'd0;
  logic [2:0]    rx_kind = 3'd0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          swp_we = 1'b0;
  logic [15:0]   swp_wdata = 16'd0;
  logic [15:0]   swp_q;
  logic          buf_empty;
  logic          irq_clr_we = 1'b0;
  logic [15:0]   irq_clr_data = 16'd0;
  logic [15:0]   irq_flags;

  rx_ring_writer #(.BASE_LOG2(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_size_idx(cfg_size_idx),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .rx_errs(rx_errs), .rx_kind(rx_kind),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .swp_we(swp_we), .swp_wdata(swp_wdata), .swp_q(swp_q), .buf_empty(buf_empty),
    .irq_clr_we(irq_clr_we), .irq_clr_data(irq_clr_data), .irq_flags(irq_flags)
  );

  // RAM model and write bookkeeping
  logic [7:0] ram [RAMN];
  int n_wr = 0;
  int n_addr_bad = 0;
  int size = 64;
  always @(posedge clk) if (mem_we) begin
    ram[mem_addr] <= mem_wdata;
    n_wr <= n_wr + 1;
    if (int'(mem_addr) >= size) n_addr_bad <= n_addr_bad + 1;
  end

  int n_run = 0, n_fail = 0;
  int ew = 0, rdreg = 16'hFFF0;

  function automatic int r4(int v);
    return ((v + 3) / 4) * 4;
  endfunction

  function automatic int cons_now();
    return ((rdreg + 16) & 16'hFFFF) % size;
  endfunction

  function automatic int stat_of(logic [4:0] e, logic [2:0] k);
    return ((e == 5'd0) ? 1 : 0) | (int'(e) << 1) | (int'(k) << 13);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(int idx);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_size_idx = idx[1:0];
    size = 64 << ((idx == 3) ? 2 : idx);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ew = 0;
    rdreg = 16'hFFF0;
    @(negedge clk);
  endtask

  task automatic send(int len, logic [4:0] e, logic [2:0] k, int seed, int gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_data  = 8'((seed + i) & 255);
      rx_errs  = (i == len - 1) ? e : 5'd0;
      rx_kind  = (i == len - 1) ? k : 3'd0;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic swp_write(int v);
    @(negedge clk);
    swp_we = 1'b1; swp_wdata = 16'(v);
    @(negedge clk);
    swp_we = 1'b0;
    rdreg = v & 16'hFFFF;
  endtask

  task automatic irq_clear(logic [15:0] m);
    @(negedge clk);
    irq_clr_we = 1'b1; irq_clr_data = m;
    @(negedge clk);
    irq_clr_we = 1'b0; irq_clr_data = 16'd0;
  endtask

  task automatic check_record(int at, int len, logic [4:0] e, logic [2:0] k, int seed);
    int bad;
    chk("R2 header status", {ram[at % size], 8'h00} >> 8 | (int'(ram[(at + 1) % size]) << 8),
        stat_of(e, k));
    chk("R1 header length", int'(ram[(at + 2) % size]) | (int'(ram[(at + 3) % size]) << 8), len);
    bad = 0;
    for (int i = 0; i < len; i++)
      if (int'(ram[(at + 4 + i) % size]) != ((seed + i) & 255)) bad++;
    chk("R3 payload bytes mismatched", bad, 0);
  endtask

  task automatic frame_step(int len, logic [4:0] e, logic [2:0] k, bit consume);
    int used, free_b, seed;
    bit fit;
    used   = (ew - cons_now() + size) % size;
    free_b = size - used;
    fit    = r4(len + 4) < free_b;
    seed   = len * 7 + 1;
    irq_clear(16'hFFFF);
    chk("R7 flags cleared by w1c", int'(irq_flags), 0);
    send(len, e, k, seed, 5);
    settle(2);
    if (fit) begin
      check_record(ew, len, e, k, seed);
      chk("R7 rxok flag", int'(irq_flags[0]), (e == 5'd0) ? 1 : 0);
      chk("R6 no drop flag on fit", int'(irq_flags[4]), 0);
      chk("R5 not empty after commit", int'(buf_empty), 0);
      ew = (ew + r4(len + 4)) % size;  // R4 offset advance
    end else begin
      chk("R6 drop flag", int'(irq_flags[4]), 1);
      chk("R6 no rxok on drop", int'(irq_flags[0]), 0);
      chk("R6 empty unchanged on drop", int'(buf_empty), (ew == cons_now()) ? 1 : 0);
    end
    if (consume) begin
      swp_write((ew - 16) & 16'hFFFF);
      chk("R5 read pointer holds write", int'(swp_q), (ew - 16) & 16'hFFFF);
      chk("R5 empty after consume", int'(buf_empty), 1);
    end
  endtask

  // Watchdog
  initial begin
    #1900us;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int w0;
    do_reset(0);
    chk("R5 reset read pointer", int'(swp_q), 16'hFFF0);
    chk("R5 reset empty", int'(buf_empty), 1);
    chk("R7 reset flags", int'(irq_flags), 0);

    // R10: bytes outside a frame
    w0 = n_wr;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 3); rx_data = 8'hA5;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b0;
    settle(8);
    chk("R10 no writes outside frame", n_wr - w0, 0);
    chk("R10 still empty", int'(buf_empty), 1);

    // R5: visibility edge, and R4 first record at offset 0
    send(8, 5'd0, 3'b010, 11, 1);
    settle(4);
    chk("R5 hidden before commit", int'(buf_empty), 1);
    settle(1);
    chk("R5 visible after commit", int'(buf_empty), 0);
    check_record(0, 8, 5'd0, 3'b010, 11);
    ew = r4(8 + 4);
    chk("R4 second offset", ew, 12);
    swp_write(ew - 16);
    chk("R5 empty after consume", int'(buf_empty), 1);

    // R9: frame start inside the header window
    irq_clear(16'hFFFF);
    send(8, 5'd0, 3'b001, 40, 1);
    send(3, 5'd0, 3'b100, 90, 5);
    settle(2);
    chk("R9 overrun flag", int'(irq_flags[6]), 1);
    chk("R9 pending record stored flag", int'(irq_flags[0]), 1);
    check_record(ew, 8, 5'd0, 3'b001, 40);
    ew = (ew + 12) % size;

    // R7: w1c only touches selected bits
    irq_clear(16'h0040);
    chk("R7 bit6 cleared", int'(irq_flags[6]), 0);
    chk("R7 bit0 kept", int'(irq_flags[0]), 1);

    // R9: the dropped frame left no trace; next record follows directly
    frame_step(5, 5'b10101, 3'b101, 1'b1);
    // R2: every error bit and class bit
    frame_step(6, 5'b01010, 3'b010, 1'b1);

    // Sweeps over all ring sizes (R3 wrap, R6 drop, R8 size)
    for (int idx = 0; idx < 4; idx++) begin
      do_reset(idx);
      for (int len = 1; len <= size / 2 + 10; len++) begin
        logic [4:0] e;
        e = (len % 4 == 0) ? 5'((len / 4) % 32) : 5'd0;
        frame_step(len, e, 3'(len % 8), (len % 5) != 0);
      end
      chk("R8 addresses inside ring", n_addr_bad, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule